// File: doc/BRIEF.md
# Strobe-Handshake Host Port

This block is the slave side of a parallel host port. An asynchronous host reaches a small bank of 16-bit registers and a 32-bit-wide word memory over a 16-bit data path. The host selects the port with an active-low chip select. It sets the direction line high to read and low to write, and frames each access with an active-low strobe. A 5-bit address picks the target. The strobe is brought into the system clock domain through a two-flop synchronizer. Each access then answers with an active-low acknowledge after a fixed number of clocks, and that number depends on the kind of access.

Memory is reached through a window address and a word pointer register. A 32-bit word travels as two consecutive 16-bit accesses, low half first. A write stores nothing until the second half arrives, and then commits the assembled word. A read fetches the whole word on the first half, holds the upper half, and hands it out on the second. After each completed word the pointer steps forward.

An interrupt output is raised by a pulse from the surrounding core. Any register write clears it after a fixed delay. Bus and acknowledge tristate are shown as drive-enable outputs for the pad ring.

Top module: `strobe_host_port`

## Requirements
- R1: `data_oe` is high exactly while `cs_n` is low, `rd_wr` is high and `stb_n` is low. From the acknowledge onward, `data_out` carries the value that the read returns.
- R2: Addresses 0 to 7 are 16-bit read/write registers. Latency is counted in rising clock edges, and edge 1 is the first edge to sample `stb_n` low. A register write (any address except 0x11 with `rd_wr` low) is acknowledged at edge 3.
- R3: A register read is acknowledged at edge 5. Registers 0 to 7 return their contents. The pointer at 0x10 returns the 11-bit word pointer zero-extended. Every other address except 0x11 reads 0 and ignores writes.
- R4: Address 0x11 is the memory window. The first (low) write half is acknowledged at edge 4 and only latched. The second (high) write half is acknowledged at edge 8 and stores {high, low} into the word at the pointer.
- R5: The first read half through 0x11 is acknowledged at edge 10. It returns bits 15:0 of the word at the pointer and holds bits 31:16. The second read half is acknowledged at edge 4 and returns the held bits.
- R6: The acknowledge is driven only low (`ack_n` is 0 whenever `ack_oe` is 1). `ack_oe` falls by the second rising edge after `stb_n` returns high.
- R7: While `cs_n` is high, a strobe produces no acknowledge and no bus drive, and a write changes nothing.
- R8: A one-cycle `irq_set` pulse drives `irq` high from the next edge. A register write clears `irq` at edge 6 and not before. Window accesses leave `irq` unchanged. If a set and a clear land on the same edge, the set wins.
- R9: The pointer increments after each second half, read or write, and wraps from 2047 to 0. A write to the pointer returns the half select to the low half.
- R10: After reset, `ack_oe`, `data_oe` and `irq` are low, and all registers and the pointer read 0.
- R11: With `cs_n` held low, back-to-back accesses each begin on a new strobe falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| stb_n | input | 1 | Access strobe, active low, asynchronous |
| addr | input | 5 | Target address |
| data_in | input | 16 | Write data from host |
| data_out | output | 16 | Read data toward host |
| data_oe | output | 1 | Data bus drive enable |
| ack_n | output | 1 | Acknowledge value, active low |
| ack_oe | output | 1 | Acknowledge drive enable |
| irq_set | input | 1 | Interrupt raise pulse from the core |
| irq | output | 1 | Interrupt output |

## Verification
The acknowledge is compared on every clock against a counting model. This is done for register writes, register reads and the four memory half-kinds, so a latency that is off by one edge, or two kinds that share a latency, shows up at once. Memory sequences use distinct words at neighbouring addresses and at the top address. These sequences separate a wrong half order, an early commit on the first write half, a missing prefetch and a failed wrap. The interrupt is probed one edge before and at its clear point, and is checked against window writes, so a clear that comes early or comes from the wrong source is caught. Unselected strobes and a pointer rewrite in the middle of a word test that no stray state is left behind.

// File: rtl/hp_pkg.sv
`timescale 1ns/1ps
package hp_pkg;

   typedef enum logic [2:0] {
      ACC_REG_WR,
      ACC_REG_RD,
      ACC_MWR_LO,
      ACC_MWR_HI,
      ACC_MRD_LO,
      ACC_MRD_HI
   } acc_kind_e;

   localparam int unsigned LAT_W       = 4;
   localparam int unsigned IRQ_CLR_CYC = 6;

   // edges from first low sample of the strobe to acknowledge
   function automatic logic [LAT_W-1:0] ack_latency(input acc_kind_e k);
      case (k)
         ACC_REG_WR: return LAT_W'(3);
         ACC_REG_RD: return LAT_W'(5);
         ACC_MWR_LO: return LAT_W'(4);
         ACC_MWR_HI: return LAT_W'(8);
         ACC_MRD_LO: return LAT_W'(10);
         ACC_MRD_HI: return LAT_W'(4);
         default:    return LAT_W'(5);
      endcase
   endfunction

endpackage

// File: rtl/hp_strobe_sync.sv
`timescale 1ns/1ps
module hp_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_n,
   output logic strobe_hi,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hp_strobe_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], stb_n};
         prev  <= chain[STAGES-1];
      end
   end

   assign strobe_hi = chain[STAGES-1];
   assign fall      = prev & ~chain[STAGES-1];

   // R11: each falling edge is reported for one cycle only
   a_r11_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);

endmodule

// File: rtl/hp_ack_seq.sv
`timescale 1ns/1ps
module hp_ack_seq #(
   parameter int LAT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LAT_W-1:0] lat,
   input  logic             strobe_hi,
   output logic             fire,
   output logic             ack_drive
);
   typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_HELD} sq_state_e;

   localparam logic [LAT_W-1:0] LAT_MIN = LAT_W'(3);
   localparam logic [LAT_W-1:0] LAT_OFS = LAT_W'(4);

   sq_state_e        st;
   logic [LAT_W-1:0] cnt;
   logic             quick;

   assign quick     = (lat <= LAT_MIN);
   assign fire      = (st == SQ_IDLE && start && quick) ||
                      (st == SQ_WAIT && cnt == '0 && !strobe_hi);
   assign ack_drive = (st == SQ_HELD) && !strobe_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= SQ_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            SQ_IDLE: if (start) begin
               if (quick) st <= SQ_HELD;
               else begin
                  cnt <= lat - LAT_OFS;
                  st  <= SQ_WAIT;
               end
            end
            SQ_WAIT: begin
               if (strobe_hi)      st  <= SQ_IDLE;
               else if (cnt == '0) st  <= SQ_HELD;
               else                cnt <= cnt - 1'b1;
            end
            SQ_HELD: if (strobe_hi) st <= SQ_IDLE;
            default: st <= SQ_IDLE;
         endcase
      end
   end

   a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_hi |=> !ack_drive);

   a_r2_fire_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);

endmodule

// File: rtl/hp_word_mem.sv
`timescale 1ns/1ps
module hp_word_mem #(
   parameter int DEPTH = 2048,
   parameter int WIDTH = 32,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
      if (re) rdata <= store[raddr];
   end

endmodule

// File: rtl/strobe_host_port.sv
`timescale 1ns/1ps
module strobe_host_port #(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 5,
   parameter int MEM_DEPTH   = 2048,
   parameter int NUM_REGS    = 8,
   parameter int PTR_ADDR    = 16,
   parameter int WIN_ADDR    = 17,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_wr,
   input  logic              stb_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic              ack_n,
   output logic              ack_oe,
   input  logic              irq_set,
   output logic              irq
);
   import hp_pkg::*;

   localparam int MEM_AW   = $clog2(MEM_DEPTH);
   localparam int WORD_W   = 2 * DATA_W;
   localparam int CLR_W    = 4;
   localparam int CLR_LOAD = int'(IRQ_CLR_CYC) - int'(ack_latency(ACC_REG_WR)) - 1;

   // elaboration checks
   if (SYNC_STAGES != 2) begin : g_bad_sync
      $error("strobe_host_port: latencies assume a two-stage synchronizer");
   end
   if ((1 << MEM_AW) != MEM_DEPTH) begin : g_bad_depth
      $error("strobe_host_port: MEM_DEPTH must be a power of two");
   end
   if (MEM_AW > DATA_W) begin : g_bad_ptr
      $error("strobe_host_port: pointer wider than data path");
   end
   if (NUM_REGS > PTR_ADDR || PTR_ADDR == WIN_ADDR || WIN_ADDR >= (1 << ADDR_W)) begin : g_bad_map
      $error("strobe_host_port: address map overlap");
   end
   if (CLR_LOAD < 0) begin : g_bad_clr
      $error("strobe_host_port: interrupt clear delay too short");
   end

   logic              sel, strobe_hi, fall, start, fire, ack_drive;
   acc_kind_e         kind;
   logic [LAT_W-1:0]  lat;
   logic              half_q;
   logic [MEM_AW-1:0] ptr_q;
   logic [DATA_W-1:0] wlow_q, uhold_q, rdata_q, rd_val;
   logic [WORD_W-1:0] mem_q;
   logic              clr_pend;
   logic [CLR_W-1:0]  clr_cnt;
   logic              is_win, is_ptr;
   logic [DATA_W-1:0] reg_bank [NUM_REGS];

   assign sel    = ~cs_n;
   assign is_win = (addr == ADDR_W'(WIN_ADDR));
   assign is_ptr = (addr == ADDR_W'(PTR_ADDR));
   assign start  = fall & sel;

   always_comb begin
      if (is_win) begin
         if (rd_wr) kind = half_q ? ACC_MRD_HI : ACC_MRD_LO;
         else       kind = half_q ? ACC_MWR_HI : ACC_MWR_LO;
      end else begin
         kind = rd_wr ? ACC_REG_RD : ACC_REG_WR;
      end
   end

   assign lat = ack_latency(kind);

   hp_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb_n     (stb_n),
      .strobe_hi (strobe_hi),
      .fall      (fall)
   );

   hp_ack_seq #(.LAT_W(LAT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .lat       (lat),
      .strobe_hi (strobe_hi),
      .fire      (fire),
      .ack_drive (ack_drive)
   );

   hp_word_mem #(.DEPTH(MEM_DEPTH), .WIDTH(WORD_W)) u_mem (
      .clk   (clk),
      .we    (fire && kind == ACC_MWR_HI),
      .waddr (ptr_q),
      .wdata ({data_in, wlow_q}),
      .re    (start && kind == ACC_MRD_LO),
      .raddr (ptr_q),
      .rdata (mem_q)
   );

   // general register bank
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else if (fire && kind == ACC_REG_WR && addr == ADDR_W'(g)) q <= data_in;
      end
      assign reg_bank[g] = q;
   end

   always_comb begin
      rd_val = '0;
      if (is_ptr) rd_val = DATA_W'(ptr_q);
      for (int i = 0; i < NUM_REGS; i++) begin
         if (addr == ADDR_W'(i)) rd_val = reg_bank[i];
      end
   end

   // word assembly, pointer and read data
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q  <= 1'b0;
         ptr_q   <= '0;
         wlow_q  <= '0;
         uhold_q <= '0;
         rdata_q <= '0;
      end else if (fire) begin
         case (kind)
            ACC_REG_WR: if (is_ptr) begin
               ptr_q  <= data_in[MEM_AW-1:0];
               half_q <= 1'b0;
            end
            ACC_REG_RD: rdata_q <= rd_val;
            ACC_MWR_LO: begin
               wlow_q <= data_in;
               half_q <= 1'b1;
            end
            ACC_MWR_HI: begin
               ptr_q  <= ptr_q + 1'b1;
               half_q <= 1'b0;
            end
            ACC_MRD_LO: begin
               rdata_q <= mem_q[DATA_W-1:0];
               uhold_q <= mem_q[WORD_W-1:DATA_W];
               half_q  <= 1'b1;
            end
            ACC_MRD_HI: begin
               rdata_q <= uhold_q;
               ptr_q   <= ptr_q + 1'b1;
               half_q  <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   // interrupt with delayed clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq      <= 1'b0;
         clr_pend <= 1'b0;
         clr_cnt  <= '0;
      end else begin
         if (fire && kind == ACC_REG_WR) begin
            clr_pend <= 1'b1;
            clr_cnt  <= CLR_W'(CLR_LOAD);
         end else if (clr_pend) begin
            if (clr_cnt == '0) clr_pend <= 1'b0;
            else               clr_cnt  <= clr_cnt - 1'b1;
         end
         if (irq_set)                               irq <= 1'b1;
         else if (clr_pend && clr_cnt == '0)        irq <= 1'b0;
      end
   end

   assign data_out = rdata_q;
   assign data_oe  = sel & rd_wr & ~stb_n;
   assign ack_oe   = sel & ack_drive;
   assign ack_n    = ~ack_drive;

   a_r7_quiet_unselected: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (!ack_oe && !data_oe));

   a_r8_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |=> irq);

   a_r4_low_half_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && kind == ACC_MWR_LO) |=> half_q);

   a_r9_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && kind == ACC_MRD_HI) |=> (ptr_q == MEM_AW'($past(ptr_q) + 1'b1)));

   a_r5_prefetch_low: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && kind == ACC_MRD_LO) |=> (rdata_q == $past(mem_q[DATA_W-1:0])));

endmodule

// File: tb/tb_strobe_host_port.sv
`timescale 1ns/1ps
module tb_strobe_host_port;
   localparam logic [4:0] PTR = 5'h10;
   localparam logic [4:0] WIN = 5'h11;

   logic        clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rd_wr = 1'b1, stb_n = 1'b1, irq_set = 1'b0;
   logic [4:0]  addr = '0;
   logic [15:0] data_in = '0;
   logic [15:0] data_out;
   logic        data_oe, ack_n, ack_oe, irq;

   always #10 clk = ~clk;

   strobe_host_port dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr(rd_wr), .stb_n(stb_n),
      .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
      .ack_n(ack_n), .ack_oe(ack_oe), .irq_set(irq_set), .irq(irq)
   );

   int    n_chk = 0, n_fail = 0;
   bit    checking = 0, done = 0;
   bit    m_sel = 0, m_low = 0, m_acked = 0;
   int    m_lat = 0, ecnt = 0, rcnt = 0;
   string m_tag = "R10";
   bit    exp_ack, exp_doe;

   // edge counters of the reference model
   always @(posedge clk) begin
      if (m_low) ecnt++;
      else       rcnt++;
   end

   // per-clock comparison against the counting model
   always @(negedge clk) begin
      if (checking && !done) begin
         exp_ack = m_sel && (m_low ? (ecnt >= m_lat) : (m_acked && rcnt < 2));
         exp_doe = !cs_n && rd_wr && !stb_n;
         n_chk++;
         if (ack_oe !== exp_ack) begin
            n_fail++;
            $display("FAIL %s ack_oe act=%b exp=%b (edge %0d)", m_tag, ack_oe, exp_ack, ecnt);
         end
         n_chk++;
         if (data_oe !== exp_doe) begin
            n_fail++;
            $display("FAIL R1 data_oe act=%b exp=%b", data_oe, exp_doe);
         end
         if (ack_oe) begin
            n_chk++;
            if (ack_n !== 1'b0) begin
               n_fail++;
               $display("FAIL R6 ack_n act=%b exp=0", ack_n);
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic access(input bit sel, input bit rd, input logic [4:0] a,
                         input logic [15:0] d, input int lat, input string tag,
                         input bit probe, output logic [15:0] rdat);
      @(posedge clk); #3;
      cs_n = !sel; rd_wr = rd; addr = a; data_in = d; stb_n = 1'b0;
      m_sel = sel; m_tag = tag; m_lat = lat; ecnt = 0; m_low = 1;
      if (probe) begin
         repeat (5) @(posedge clk);
         @(negedge clk); chk("R8 irq before clear", {15'd0, irq}, 16'd1);
         @(posedge clk);
         @(negedge clk); chk("R8 irq cleared", {15'd0, irq}, 16'd0);
      end else begin
         repeat (lat + 1) @(posedge clk);
         @(negedge clk);
      end
      rdat = data_out;
      @(posedge clk); #3;
      stb_n = 1'b1;
      m_acked = sel && (ecnt >= m_lat);
      m_low = 0; rcnt = 0;
      repeat (3) @(posedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d, input int lat, input string tag);
      logic [15:0] junk;
      access(1'b1, 1'b0, a, d, lat, tag, 1'b0, junk);
   endtask

   task automatic rd_chk(input logic [4:0] a, input int lat, input logic [15:0] exp, input string tag);
      logic [15:0] v;
      access(1'b1, 1'b1, a, 16'h0, lat, tag, 1'b0, v);
      chk(tag, v, exp);
   endtask

   task automatic pulse_irq();
      @(posedge clk); #3 irq_set = 1'b1;
      @(posedge clk); #3 irq_set = 1'b0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      logic [15:0] junk;
      repeat (3) @(posedge clk);
      #3 rst_n = 1'b1;
      checking = 1;
      @(negedge clk);
      // R10: reset state
      chk("R10 ack_oe", {15'd0, ack_oe}, 16'd0);
      chk("R10 data_oe", {15'd0, data_oe}, 16'd0);
      chk("R10 irq", {15'd0, irq}, 16'd0);
      rd_chk(5'd2, 5, 16'h0000, "R10");
      rd_chk(PTR, 5, 16'h0000, "R10");

      // R2 / R3: register bank
      wr(5'd3, 16'hA5A5, 3, "R2");
      wr(5'd0, 16'h1111, 3, "R2");
      wr(5'd7, 16'hFEDC, 3, "R2");
      rd_chk(5'd3, 5, 16'hA5A5, "R3");
      rd_chk(5'd0, 5, 16'h1111, "R3");
      rd_chk(5'd7, 5, 16'hFEDC, "R3");
      wr(5'h1F, 16'hFFFF, 3, "R3");
      rd_chk(5'h1F, 5, 16'h0000, "R3");

      // R4 / R11: two words written back to back
      wr(PTR, 16'd5, 3, "R9");
      wr(WIN, 16'h1234, 4, "R4");
      wr(WIN, 16'hABCD, 8, "R4");
      wr(WIN, 16'h5555, 4, "R11");
      wr(WIN, 16'h6666, 8, "R11");
      rd_chk(PTR, 5, 16'd7, "R9");

      // R5: read the words back
      wr(PTR, 16'd5, 3, "R9");
      rd_chk(WIN, 10, 16'h1234, "R5");
      rd_chk(WIN, 4, 16'hABCD, "R5");
      rd_chk(WIN, 10, 16'h5555, "R5");
      rd_chk(WIN, 4, 16'h6666, "R5");
      rd_chk(PTR, 5, 16'd7, "R9");

      // R7: unselected strobes
      access(1'b0, 1'b0, 5'd3, 16'h0000, 8, "R7", 1'b0, junk);
      access(1'b0, 1'b1, 5'd3, 16'h0000, 8, "R7", 1'b0, junk);
      rd_chk(5'd3, 5, 16'hA5A5, "R7");

      // R9: pointer rewrite mid-word, no commit
      wr(PTR, 16'd5, 3, "R9");
      wr(WIN, 16'h9999, 4, "R9");
      wr(PTR, 16'd5, 3, "R9");
      rd_chk(WIN, 10, 16'h1234, "R9");
      rd_chk(WIN, 4, 16'hABCD, "R9");

      // R9: wrap at the top word
      wr(PTR, 16'd2047, 3, "R9");
      wr(WIN, 16'hBEEF, 4, "R4");
      wr(WIN, 16'hCAFE, 8, "R4");
      rd_chk(PTR, 5, 16'd0, "R9");
      wr(PTR, 16'd2047, 3, "R9");
      rd_chk(WIN, 10, 16'hBEEF, "R5");
      rd_chk(WIN, 4, 16'hCAFE, "R5");

      // R8: interrupt raise and clear
      pulse_irq();
      @(negedge clk); chk("R8 raised", {15'd0, irq}, 16'd1);
      access(1'b1, 1'b0, 5'd2, 16'h0042, 3, "R8", 1'b1, junk);
      pulse_irq();
      wr(WIN, 16'h0101, 4, "R8");
      @(negedge clk); chk("R8 window keeps irq", {15'd0, irq}, 16'd1);
      wr(WIN, 16'h0202, 8, "R8");
      @(negedge clk); chk("R8 window keeps irq", {15'd0, irq}, 16'd1);
      rd_chk(5'd2, 5, 16'h0042, "R2");

      done = 1;
      summary();
      $finish;
   end

   initial begin
      #4_000_000;
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL R11 watchdog act=running exp=finished");
         summary();
         $finish;
      end
   end

endmodule